// File: doc/BRIEF.md
# Threshold-Burst Request and Drain Controller

This block sits beside a pair of byte FIFOs, one for received data and one for data to transmit, and decides when the host or a DMA engine should move data. Requests come in bursts sized by a programmable threshold: a burst covers `threshold + 1` bytes. The FIFO storage and the serial bus engine live elsewhere. The block sees the FIFO fill levels and the host read/write strobes. It hands back accept strobes that gate the FIFO pointers, flush strobes, DMA requests, five write-1-to-clear event flags and two remaining-byte counts.

At the start of a transfer the programmed byte count is loaded into a receive counter and a transmit counter. Each byte the host accepts counts one of them down. When fewer than a full burst of bytes remain, this count equals the transfer length modulo `threshold + 1`. Drain handling then raises a drain flag and, with DMA enabled, a short final burst of exactly the remaining length.

Each direction has its own burst state machine with three states: `BR_IDLE`, `BR_FULL` and `BR_DRAIN`.
- **Start of a full burst:** `BR_IDLE` moves to `BR_FULL`, loading `threshold + 1`.
- **Start of a drain burst:** `BR_IDLE` moves to `BR_DRAIN`, loading the remaining count.
- **Burst completion:** `BR_FULL` or `BR_DRAIN` returns to `BR_IDLE` on the accepted access that takes the burst count from 1 to 0.
- **Abort:** either busy state returns to `BR_IDLE` on a FIFO clear or when DMA is disabled.

The DMA request is high in every state except `BR_IDLE`.

Top module: `burst_req_ctrl`

## Requirements
- R1: After reset, all five flags, both DMA requests and both remaining counts are zero.
- R2: The receive-ready flag (flag bit 0) sets on the clock edge where `rx_level >= rx_thresh + 1`.
- R3: With `rx_dma_en` set and `rx_level >= rx_thresh + 1`, `rx_dma_req` rises after the next edge. It stays high until `rx_thresh + 1` reads have been accepted, and falls after the edge of the last one.
- R4: The transmit-ready flag (bit 1) sets when `tx_stat != 0` and `tx_level < tx_thresh + 1`. It does not set when the level is at or above `tx_thresh + 1`.
- R5: With `tx_dma_en` set, `tx_level == 0` and `tx_stat != 0`, `tx_dma_req` rises after the next edge. It falls after the edge of the `tx_thresh + 1`-th accepted write.
- R6: Flags are write-1-to-clear. The bit map is 0 receive-ready, 1 transmit-ready, 2 receive-drain, 3 transmit-drain, 4 access-error. A 1 in `flag_w1c` clears that flag at the next edge. If its condition still holds, the flag sets again one edge later.
- R7: A host read while `rx_level == 0`, or a host write while `tx_level == DEPTH`, is refused (`rd_accept`/`wr_accept` low) and sets the access-error flag. A refused access leaves the remaining counts unchanged.
- R8: `xfer_start` loads `xfer_len` into `rx_stat` and `tx_stat`. Each accepted read or write lowers its count by one, stopping at zero.
- R9: With `rx_drain_en` set, the receive-drain flag sets when `rx_stat` is between 1 and `rx_thresh` and `rx_level == rx_stat`. With `rx_dma_en` set, the same condition also starts a drain burst of exactly `rx_stat` reads.
- R10: With `tx_drain_en` set, the transmit-drain flag sets when `tx_stat` is between 1 and `tx_thresh`. With `tx_dma_en` set and the FIFO empty, the same condition also starts a drain burst of exactly `tx_stat` writes.
- R11: With the drain enables low, no drain flag sets. A partial receive tail raises no request. A transmit burst keeps its full length, so its request stays high when too few bytes arrive.
- R12: A clear bit drives its flush output in the same cycle and blocks host accesses in that cycle. It also returns that direction's burst machine to `BR_IDLE`, so the request is low after the edge.
- R13: `tx_can_send` is high whenever `tx_level != 0`, whatever the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| host_rd | input | 1 | Host/DMA read strobe from the receive FIFO |
| host_wr | input | 1 | Host/DMA write strobe into the transmit FIFO |
| rx_thresh | input | TH_W | Receive burst threshold (burst = value + 1) |
| tx_thresh | input | TH_W | Transmit burst threshold (burst = value + 1) |
| xfer_len | input | CNT_W | Programmed transfer byte count |
| xfer_start | input | 1 | Loads the remaining counts |
| rx_dma_en | input | 1 | Receive DMA enable |
| tx_dma_en | input | 1 | Transmit DMA enable |
| rx_drain_en | input | 1 | Receive drain enable |
| tx_drain_en | input | 1 | Transmit drain enable |
| rx_clr | input | 1 | Receive FIFO clear |
| tx_clr | input | 1 | Transmit FIFO clear |
| flag_w1c | input | NFLAG | Write-1-to-clear strobes per flag |
| rd_accept | output | 1 | Read accepted, moves receive pointer |
| wr_accept | output | 1 | Write accepted, moves transmit pointer |
| rx_flush | output | 1 | Empty the receive FIFO |
| tx_flush | output | 1 | Empty the transmit FIFO |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| irq_flags | output | NFLAG | Sticky event flags |
| rx_stat | output | CNT_W | Receive bytes remaining |
| tx_stat | output | CNT_W | Transmit bytes remaining |
| tx_can_send | output | 1 | Bus side may transmit |

## Verification
Properties checked on every cycle:
- A flag whose condition holds without a clear is set at the next edge, and a clear always empties its flag.
- A DMA request never falls except after an accepted access, a clear or a disable.
- A request that sees none of these stays high.
- A refused read raises the access error.
- An accepted read lowers the receive count by exactly one.

Only the directed scenarios can show:
- the exact burst lengths, and the fact that a drain burst is sized by the remaining count;
- the one-cycle dip and re-set of a cleared flag;
- that a burst left incomplete keeps requesting until the FIFO is cleared.

// File: rtl/burst_req_pkg.sv
package burst_req_pkg;

    localparam int F_RRDY = 0;
    localparam int F_XRDY = 1;
    localparam int F_RDR  = 2;
    localparam int F_XDR  = 3;
    localparam int F_AERR = 4;
    localparam int NFLAG  = 5;

    typedef enum logic [1:0] {
        BR_IDLE  = 2'd0,
        BR_FULL  = 2'd1,
        BR_DRAIN = 2'd2
    } burst_state_t;

endpackage

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_req_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             start_full,
    input  logic             start_drain,
    input  logic [CNT_W-1:0] full_len,
    input  logic [CNT_W-1:0] drain_len,
    input  logic             acc,
    output logic             req
);

    burst_state_t     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (clr || !en) begin
            state_d = BR_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                BR_IDLE: begin
                    if (start_full) begin
                        state_d = BR_FULL;
                        cnt_d   = full_len;
                    end else if (start_drain) begin
                        state_d = BR_DRAIN;
                        cnt_d   = drain_len;
                    end
                end
                BR_FULL, BR_DRAIN: begin
                    if (acc) begin
                        if (cnt_q <= 1) begin
                            state_d = BR_IDLE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = BR_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            BR_FULL, BR_DRAIN: req = 1'b1;
            default:           req = 1'b0;
        endcase
    end

    // R3 R5: a request only ends through an access, a clear or a disable
    a_r3_req_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(acc || clr || !en));

    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !acc && !clr && en) |=> req);

endmodule

// File: rtl/w1c_flags.sv
module w1c_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] w1c,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (w1c[i]) flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
        end

        // R6: condition without a clear sets the flag at the next edge
        a_r6_set_seen: assert property (@(posedge clk) disable iff (!rst_n)
            (set[i] && !w1c[i]) |=> flags[i]);

        // R6: a clear always empties the flag at the next edge
        a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            w1c[i] |=> !flags[i]);
    end

endmodule

// File: rtl/burst_req_ctrl.sv
module burst_req_ctrl
    import burst_req_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = 16,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int TH_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             host_rd,
    input  logic             host_wr,
    input  logic [TH_W-1:0]  rx_thresh,
    input  logic [TH_W-1:0]  tx_thresh,
    input  logic [CNT_W-1:0] xfer_len,
    input  logic             xfer_start,
    input  logic             rx_dma_en,
    input  logic             tx_dma_en,
    input  logic             rx_drain_en,
    input  logic             tx_drain_en,
    input  logic             rx_clr,
    input  logic             tx_clr,
    input  logic [NFLAG-1:0] flag_w1c,
    output logic             rd_accept,
    output logic             wr_accept,
    output logic             rx_flush,
    output logic             tx_flush,
    output logic             rx_dma_req,
    output logic             tx_dma_req,
    output logic [NFLAG-1:0] irq_flags,
    output logic [CNT_W-1:0] rx_stat,
    output logic [CNT_W-1:0] tx_stat,
    output logic             tx_can_send
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [CNT_W-1:0] rx_left_q, tx_left_q;
    logic [CNT_W-1:0] rx_burst, tx_burst;
    logic [CNT_W-1:0] rx_lvl_x, tx_lvl_x;
    logic             rx_full_c, rx_drain_c, tx_xrdy_c, tx_drain_c;
    logic             rx_bad, tx_bad;
    logic [NFLAG-1:0] flag_set;

    assign rx_burst = CNT_W'(rx_thresh) + 1'b1;
    assign tx_burst = CNT_W'(tx_thresh) + 1'b1;
    assign rx_lvl_x = CNT_W'(rx_level);
    assign tx_lvl_x = CNT_W'(tx_level);

    // host access gating
    assign rx_bad    = host_rd && (rx_level == '0);
    assign tx_bad    = host_wr && (tx_level == FULL_LVL);
    assign rd_accept = host_rd && !rx_bad && !rx_clr;
    assign wr_accept = host_wr && !tx_bad && !tx_clr;
    assign rx_flush  = rx_clr;
    assign tx_flush  = tx_clr;
    assign tx_can_send = (tx_level != '0);

    // burst and drain conditions
    assign rx_full_c  = (rx_lvl_x >= rx_burst);
    assign rx_drain_c = rx_drain_en && (rx_left_q != '0) &&
                        (rx_left_q < rx_burst) && (rx_lvl_x == rx_left_q);
    assign tx_xrdy_c  = (tx_left_q != '0) && (tx_lvl_x < tx_burst);
    assign tx_drain_c = tx_drain_en && (tx_left_q != '0) && (tx_left_q < tx_burst);

    // remaining-byte counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_left_q <= '0;
            tx_left_q <= '0;
        end else if (xfer_start) begin
            rx_left_q <= xfer_len;
            tx_left_q <= xfer_len;
        end else begin
            if (rd_accept && rx_left_q != '0) rx_left_q <= rx_left_q - 1'b1;
            if (wr_accept && tx_left_q != '0) tx_left_q <= tx_left_q - 1'b1;
        end
    end

    assign rx_stat = rx_left_q;
    assign tx_stat = tx_left_q;

    burst_fsm #(.CNT_W(CNT_W)) u_rx_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (rx_dma_en),
        .clr         (rx_clr),
        .start_full  (rx_full_c),
        .start_drain (rx_drain_c),
        .full_len    (rx_burst),
        .drain_len   (rx_left_q),
        .acc         (rd_accept),
        .req         (rx_dma_req)
    );

    burst_fsm #(.CNT_W(CNT_W)) u_tx_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (tx_dma_en),
        .clr         (tx_clr),
        .start_full  ((tx_level == '0) && (tx_left_q != '0) && !tx_drain_c),
        .start_drain ((tx_level == '0) && tx_drain_c),
        .full_len    (tx_burst),
        .drain_len   (tx_left_q),
        .acc         (wr_accept),
        .req         (tx_dma_req)
    );

    always_comb begin
        flag_set         = '0;
        flag_set[F_RRDY] = rx_full_c;
        flag_set[F_XRDY] = tx_xrdy_c;
        flag_set[F_RDR]  = rx_drain_c;
        flag_set[F_XDR]  = tx_drain_c;
        flag_set[F_AERR] = rx_bad || tx_bad;
    end

    w1c_flags #(.N(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .w1c   (flag_w1c),
        .flags (irq_flags)
    );

    // R7: a read from an empty receive FIFO shows up as an access error
    a_r7_empty_read_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && rx_level == '0 && !flag_w1c[F_AERR]) |=> irq_flags[F_AERR]);

    // R8: an accepted read lowers the receive count by one
    a_r8_rx_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_accept && rx_stat != '0 && !xfer_start) |=> (rx_stat == $past(rx_stat) - 1'b1));

endmodule

// File: tb/burst_req_ctrl_tb_top.sv
`timescale 1ns/1ps
module burst_req_ctrl_tb_top;

    localparam int DEPTH = 32;
    localparam int CNT_W = 16;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int TH_W  = $clog2(DEPTH);
    localparam int NF    = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LVL_W-1:0] rx_level = '0, tx_level = '0;
    logic             host_rd = 1'b0, host_wr = 1'b0;
    logic [TH_W-1:0]  rx_thresh = '0, tx_thresh = '0;
    logic [CNT_W-1:0] xfer_len = '0;
    logic             xfer_start = 1'b0;
    logic             rx_dma_en = 1'b0, tx_dma_en = 1'b0;
    logic             rx_drain_en = 1'b0, tx_drain_en = 1'b0;
    logic             rx_clr = 1'b0, tx_clr = 1'b0;
    logic [NF-1:0]    flag_w1c = '0;
    logic             rd_accept, wr_accept, rx_flush, tx_flush;
    logic             rx_dma_req, tx_dma_req, tx_can_send;
    logic [NF-1:0]    irq_flags;
    logic [CNT_W-1:0] rx_stat, tx_stat;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    burst_req_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
        .host_rd(host_rd), .host_wr(host_wr), .rx_thresh(rx_thresh),
        .tx_thresh(tx_thresh), .xfer_len(xfer_len), .xfer_start(xfer_start),
        .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en), .rx_drain_en(rx_drain_en),
        .tx_drain_en(tx_drain_en), .rx_clr(rx_clr), .tx_clr(tx_clr),
        .flag_w1c(flag_w1c), .rd_accept(rd_accept), .wr_accept(wr_accept),
        .rx_flush(rx_flush), .tx_flush(tx_flush), .rx_dma_req(rx_dma_req),
        .tx_dma_req(tx_dma_req), .irq_flags(irq_flags), .rx_stat(rx_stat),
        .tx_stat(tx_stat), .tx_can_send(tx_can_send)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_flag(int idx);
        flag_w1c = NF'(1) << idx;
        tick();
        flag_w1c = '0;
    endtask

    task automatic start_xfer(int len);
        xfer_len = CNT_W'(len);
        xfer_start = 1'b1;
        tick();
        xfer_start = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 flags", int'(irq_flags), 0);
        check("R1 rx req", int'(rx_dma_req), 0);
        check("R1 tx req", int'(tx_dma_req), 0);
        check("R1 rx_stat", int'(rx_stat), 0);
        check("R1 tx_stat", int'(tx_stat), 0);
    endtask

    task automatic t_rrdy();
        rx_thresh = 3; rx_level = 3;
        tick();
        check("R2 below threshold", int'(irq_flags[0]), 0);
        rx_level = 4;
        tick();
        check("R2 at threshold+1", int'(irq_flags[0]), 1);
    endtask

    task automatic t_w1c();
        clear_flag(0);
        check("R6 cleared", int'(irq_flags[0]), 0);
        tick();
        check("R6 resets while condition holds", int'(irq_flags[0]), 1);
        rx_level = 0;
        clear_flag(0);
        tick();
        check("R6 stays clear", int'(irq_flags[0]), 0);
    endtask

    task automatic t_rx_dma();
        rx_thresh = 3; rx_level = 4; rx_dma_en = 1'b1;
        tick();
        check("R3 rx req rises", int'(rx_dma_req), 1);
        for (int i = 0; i < 4; i++) begin
            host_rd = 1'b1;
            if (i == 3) check("R3 rx req held before last read", int'(rx_dma_req), 1);
            tick();
            rx_level = rx_level - 1'b1;
        end
        host_rd = 1'b0;
        check("R3 rx req falls after burst", int'(rx_dma_req), 0);
        rx_dma_en = 1'b0;
    endtask

    task automatic t_aerr_and_count();
        rx_level = 0; host_rd = 1'b1;
        #0.5;
        check("R7 empty read refused", int'(rd_accept), 0);
        tick();
        host_rd = 1'b0;
        check("R7 empty read flag", int'(irq_flags[4]), 1);
        clear_flag(4);
        start_xfer(10);
        check("R8 rx load", int'(rx_stat), 10);
        check("R8 tx load", int'(tx_stat), 10);
        tx_level = 32; host_wr = 1'b1;
        #0.5;
        check("R7 full write refused", int'(wr_accept), 0);
        tick();
        host_wr = 1'b0;
        check("R7 full write flag", int'(irq_flags[4]), 1);
        check("R7 refused write keeps count", int'(tx_stat), 10);
        clear_flag(4);
        tx_level = 5; host_wr = 1'b1;
        #0.5;
        check("R7 normal write accepted", int'(wr_accept), 1);
        tick();
        host_wr = 1'b0;
        check("R8 tx decrement", int'(tx_stat), 9);
        rx_level = 3; host_rd = 1'b1;
        tick();
        host_rd = 1'b0; rx_level = 0;
        check("R8 rx decrement", int'(rx_stat), 9);
    endtask

    task automatic t_tx_dma();
        tx_thresh = 3; tx_level = 0; tx_dma_en = 1'b1;
        tick();
        check("R5 tx req rises on empty", int'(tx_dma_req), 1);
        check("R4 xrdy below threshold", int'(irq_flags[1]), 1);
        for (int i = 0; i < 4; i++) begin
            host_wr = 1'b1;
            if (i == 3) check("R5 tx req held before last write", int'(tx_dma_req), 1);
            tick();
            tx_level = tx_level + 1'b1;
        end
        host_wr = 1'b0;
        check("R5 tx req falls after burst", int'(tx_dma_req), 0);
        check("R8 tx count after burst", int'(tx_stat), 5);
        clear_flag(1);
        tick();
        check("R4 no xrdy at threshold+1", int'(irq_flags[1]), 0);
    endtask

    task automatic t_no_drain_and_tx_clr();
        start_xfer(2);
        tx_level = 0;
        tick();
        check("R11 full burst on short tail", int'(tx_dma_req), 1);
        check("R11 no xdr when disabled", int'(irq_flags[3]), 0);
        for (int i = 0; i < 2; i++) begin
            host_wr = 1'b1;
            tick();
            tx_level = tx_level + 1'b1;
        end
        host_wr = 1'b0;
        check("R11 req stays with too few writes", int'(tx_dma_req), 1);
        tx_clr = 1'b1;
        #0.5;
        check("R12 tx flush", int'(tx_flush), 1);
        tick();
        tx_clr = 1'b0; tx_level = 0;
        check("R12 tx req dropped by clear", int'(tx_dma_req), 0);
        rx_thresh = 3; rx_level = 2; rx_dma_en = 1'b1;
        tick();
        check("R11 no rx req on partial tail", int'(rx_dma_req), 0);
        check("R11 no rdr when disabled", int'(irq_flags[2]), 0);
    endtask

    task automatic t_rx_drain();
        rx_drain_en = 1'b1;
        tick();
        check("R9 rdr flag", int'(irq_flags[2]), 1);
        check("R9 rx drain req", int'(rx_dma_req), 1);
        check("R9 rx remaining", int'(rx_stat), 2);
        for (int i = 0; i < 2; i++) begin
            host_rd = 1'b1;
            tick();
            rx_level = rx_level - 1'b1;
        end
        host_rd = 1'b0;
        check("R9 rx drain req ends", int'(rx_dma_req), 0);
        check("R9 rx remaining zero", int'(rx_stat), 0);
        rx_dma_en = 1'b0; rx_drain_en = 1'b0;
    endtask

    task automatic t_tx_drain();
        start_xfer(6);
        tx_drain_en = 1'b1; tx_thresh = 3; tx_level = 0;
        tick();
        check("R10 full burst first", int'(tx_dma_req), 1);
        for (int i = 0; i < 4; i++) begin
            host_wr = 1'b1;
            tick();
            tx_level = tx_level + 1'b1;
        end
        host_wr = 1'b0;
        check("R10 remaining after full burst", int'(tx_stat), 2);
        tx_level = 0;
        tick();
        check("R10 xdr flag", int'(irq_flags[3]), 1);
        check("R10 drain req", int'(tx_dma_req), 1);
        for (int i = 0; i < 2; i++) begin
            host_wr = 1'b1;
            tick();
            tx_level = tx_level + 1'b1;
        end
        host_wr = 1'b0;
        check("R10 drain req ends", int'(tx_dma_req), 0);
        check("R10 remaining zero", int'(tx_stat), 0);
        tx_dma_en = 1'b0; tx_drain_en = 1'b0;
    endtask

    task automatic t_rx_clr();
        start_xfer(6);
        rx_thresh = 3; rx_level = 4; rx_dma_en = 1'b1;
        tick();
        check("R3 rx req before clear", int'(rx_dma_req), 1);
        rx_clr = 1'b1; host_rd = 1'b1;
        #0.5;
        check("R12 rx flush", int'(rx_flush), 1);
        check("R12 read blocked during clear", int'(rd_accept), 0);
        tick();
        rx_clr = 1'b0; host_rd = 1'b0; rx_level = 0;
        check("R12 rx req dropped", int'(rx_dma_req), 0);
        check("R12 blocked read keeps count", int'(rx_stat), 6);
        rx_dma_en = 1'b0;
    endtask

    task automatic t_send();
        tx_thresh = 7; tx_level = 1;
        #0.5;
        check("R13 send with one byte", int'(tx_can_send), 1);
        tx_level = 0;
        #0.5;
        check("R13 no send when empty", int'(tx_can_send), 0);
    endtask

    initial begin
        tick();
        tick();
        rst_n = 1'b1;
        t_reset();
        t_rrdy();
        t_w1c();
        t_rx_dma();
        t_aerr_and_count();
        t_tx_dma();
        t_no_drain_and_tx_clr();
        t_rx_drain();
        t_tx_drain();
        t_rx_clr();
        t_send();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule